// File: doc/BRIEF.md
# Byte-Masked Synchronous RAM

A synchronous block RAM whose writes can be limited to selected byte lanes of the word. Every input is sampled on the rising clock edge. The read word is registered, so it appears one cycle after its address was presented. A four-bit byte-enable bus picks the lanes that a write updates. A lane whose enable is low keeps the value it held before.

The word width is a parameter and takes one of 1, 2, 4, 8, 9, 16, 18, 32 or 36 bits. The lane size depends on the width. Widths of 16 and 32 use 8-bit lanes. Widths of 18 and 36 use 9-bit lanes, so a parity bit is written together with its byte. At 9 bits or fewer the whole word is a single lane, and its enable bit simply acts as a second write enable.

A mode parameter selects one of two configurations. The single-port configuration uses port A alone and gives it the whole enable bus. The true dual-port configuration allows at most 18 bits per port and gives each port a two-bit slice of the enable bus.

Top module: `bytemask_ram`

## Requirements
- R1: Lane layout: at DATA_W 16 or 32, lane k is bits [8k+7:8k]; at DATA_W 18 or 36, lane k is bits [9k+8:9k] (for 36 the top lane is [35:27]); at DATA_W of 9 or less the word is one lane.
- R2: With the write enable low, the stored word at the address sampled on a rising edge appears on the port's data output right after that edge and holds for one cycle.
- R3: With the write enable high, exactly the lanes whose byte-enable bit is 1 are overwritten with the input data, and every other lane of that word keeps its stored contents.
- R4: A write with the write enable high and all relevant byte-enable bits 0 changes no stored data.
- R5: At DATA_W of 9 or less, the lane-0 byte-enable bit (byteena[0] for port A, byteena[2] for port B) gates the whole word like a second write enable.
- R6: With the write enable low, no value on byteena or data-in changes stored data.
- R7: In a write cycle, the output lanes whose byte-enable bit is 1 show the newly written data after the edge. Lanes whose bit is 0 show an unspecified value.
- R8: In single-port mode (MODE = BMR_SINGLE), byteena[k] masks lane k of port A, and b_dout is held at zero.
- R9: In dual-port mode (MODE = BMR_DUAL, DATA_W at most 18), byteena[1:0] masks lanes 1..0 of port A and byteena[3:2] masks lanes 1..0 of port B.
- R10: In dual-port mode, a read on one port of an address the other port writes in the same cycle returns the contents from before that write.
- R11: In dual-port mode, when both ports write the same lane of the same address in one cycle, the model keeps port A's data. Lanes that only one port enables take that port's data.
- R12: While rst_n is low, a_dout and b_dout are zero. The reset does not touch the memory contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the output registers |
| a_we | input | 1 | Port A write enable |
| a_addr | input | ADDR_W | Port A word address |
| a_din | input | DATA_W | Port A write data |
| a_dout | output | DATA_W | Port A registered read data |
| b_we | input | 1 | Port B write enable (dual-port mode only) |
| b_addr | input | ADDR_W | Port B word address (dual-port mode only) |
| b_din | input | DATA_W | Port B write data (dual-port mode only) |
| b_dout | output | DATA_W | Port B registered read data; zero in single-port mode |
| byteena | input | 4 | Lane enables, split between the ports in dual-port mode |

## Verification
The interesting case is a write on one port and a read of the same word on the other port in the same edge. The bench provokes it by having port A write an address while port B reads it. It then expects the old word on B in that cycle and the new lanes on B in the next cycle. The same-edge clash of two writes is also provoked: both ports write one address with overlapping lanes. The reference array applies port B first and port A last, and the readback must show A's data in the shared lane and B's data in the lane only B enabled. Lanes that are masked during a write cycle are excluded from comparison through the expected-item mask.

// File: rtl/bmr_pkg.sv
package bmr_pkg;

  typedef enum logic {
    BMR_SINGLE = 1'b0,
    BMR_DUAL   = 1'b1
  } bmr_mode_e;

  // Bits per lane for a given word width.
  function automatic int lane_bits(input int w);
    if (w <= 9)          return w;
    else if (w % 9 == 0) return 9;
    else                 return 8;
  endfunction

  // Number of lanes for a given word width.
  function automatic int lane_count(input int w);
    return (w <= 9) ? 1 : w / lane_bits(w);
  endfunction

endpackage

// File: rtl/bmr_lane_mask.sv
module bmr_lane_mask #(
  parameter int NL = 2
) (
  input  logic          we,
  input  logic [NL-1:0] be,
  output logic [NL-1:0] lane_wr
);

  for (genvar k = 0; k < NL; k++) begin : g_lane
    assign lane_wr[k] = we & be[k];
  end

endmodule

// File: rtl/bmr_mem_array.sv
module bmr_mem_array #(
  parameter int DATA_W = 18,
  parameter int ADDR_W = 8,
  parameter int NP     = 2,
  parameter int NL     = 2,
  parameter int LW     = 9
) (
  input  logic                         clk,
  input  logic [NP-1:0][ADDR_W-1:0]    addr,
  input  logic [NP-1:0][DATA_W-1:0]    din,
  input  logic [NP-1:0][NL-1:0]        lane_wr,
  output logic [NP-1:0][DATA_W-1:0]    rd_data
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Later assignment wins: port 0 (A) is applied last.
  always_ff @(posedge clk) begin
    for (int p = NP - 1; p >= 0; p--) begin
      for (int k = 0; k < NL; k++) begin
        if (lane_wr[p][k]) begin
          mem[addr[p]][k*LW +: LW] <= din[p][k*LW +: LW];
        end
      end
    end
  end

  // Read sees contents before this edge's writes.
  for (genvar p = 0; p < NP; p++) begin : g_rd
    assign rd_data[p] = mem[addr[p]];
  end

endmodule

// File: rtl/bmr_out_stage.sv
module bmr_out_stage #(
  parameter int DATA_W = 18,
  parameter int NL     = 2,
  parameter int LW     = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [NL-1:0]     lane_wr,
  input  logic [DATA_W-1:0] din,
  input  logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] dout
);

  logic [DATA_W-1:0] dout_d;
  logic [DATA_W-1:0] dout_q;

  always_comb begin
    dout_d = rd_data;
    if (we) begin
      for (int k = 0; k < NL; k++) begin
        dout_d[k*LW +: LW] = lane_wr[k] ? din[k*LW +: LW] : {LW{1'bx}};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dout_q <= '0;
    else        dout_q <= dout_d;
  end

  assign dout = dout_q;

endmodule

// File: rtl/bytemask_ram.sv
module bytemask_ram
  import bmr_pkg::*;
#(
  parameter int        DATA_W = 18,
  parameter int        ADDR_W = 8,
  parameter bmr_mode_e MODE   = BMR_DUAL
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_we,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_din,
  output logic [DATA_W-1:0] a_dout,
  input  logic              b_we,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_din,
  output logic [DATA_W-1:0] b_dout,
  input  logic [3:0]        byteena
);

  localparam int LW = lane_bits(DATA_W);
  localparam int NL = lane_count(DATA_W);
  localparam int NP = (MODE == BMR_DUAL) ? 2 : 1;

  logic [NP-1:0]             p_we;
  logic [NP-1:0][ADDR_W-1:0] p_addr;
  logic [NP-1:0][DATA_W-1:0] p_din;
  logic [NP-1:0][NL-1:0]     p_be;
  logic [NP-1:0][NL-1:0]     p_lane_wr;
  logic [NP-1:0][DATA_W-1:0] p_rd;
  logic [NP-1:0][DATA_W-1:0] p_dout;

  assign p_we[0]   = a_we;
  assign p_addr[0] = a_addr;
  assign p_din[0]  = a_din;
  assign p_be[0]   = byteena[NL-1:0];
  assign a_dout    = p_dout[0];

  if (MODE == BMR_DUAL) begin : g_dual
    assign p_we[1]   = b_we;
    assign p_addr[1] = b_addr;
    assign p_din[1]  = b_din;
    assign p_be[1]   = byteena[2 +: NL];
    assign b_dout    = p_dout[1];
  end else begin : g_single
    assign b_dout = '0;
  end

  for (genvar p = 0; p < NP; p++) begin : g_port
    bmr_lane_mask #(
      .NL(NL)
    ) u_mask (
      .we      (p_we[p]),
      .be      (p_be[p]),
      .lane_wr (p_lane_wr[p])
    );

    bmr_out_stage #(
      .DATA_W(DATA_W),
      .NL    (NL),
      .LW    (LW)
    ) u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (p_we[p]),
      .lane_wr (p_lane_wr[p]),
      .din     (p_din[p]),
      .rd_data (p_rd[p]),
      .dout    (p_dout[p])
    );
  end

  bmr_mem_array #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W),
    .NP    (NP),
    .NL    (NL),
    .LW    (LW)
  ) u_mem (
    .clk     (clk),
    .addr    (p_addr),
    .din     (p_din),
    .lane_wr (p_lane_wr),
    .rd_data (p_rd)
  );

endmodule

// File: rtl/bmr_checker.sv
module bmr_checker
  import bmr_pkg::*;
#(
  parameter int        DATA_W = 18,
  parameter int        ADDR_W = 8,
  parameter bmr_mode_e MODE   = BMR_DUAL
) (
  input logic              clk,
  input logic              rst_n,
  input logic              a_we,
  input logic [ADDR_W-1:0] a_addr,
  input logic [DATA_W-1:0] a_din,
  input logic [DATA_W-1:0] a_dout,
  input logic              b_we,
  input logic [ADDR_W-1:0] b_addr,
  input logic [DATA_W-1:0] b_din,
  input logic [DATA_W-1:0] b_dout,
  input logic [3:0]        byteena
);

  localparam int LW = lane_bits(DATA_W);
  localparam int NL = lane_count(DATA_W);
  localparam bit DUAL = (MODE == BMR_DUAL);

  logic [1:0] since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  for (genvar k = 0; k < NL; k++) begin : g_lane
    AST_ECHO_A: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst >= 2'd1 && $past(a_we) && $past(byteena[k]))
      |-> a_dout[k*LW +: LW] == $past(a_din[k*LW +: LW])); // R7

    AST_READBACK_A: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst >= 2'd2 && $past(a_we, 2) && $past(byteena[k], 2) && !$past(a_we)
       && $past(a_addr) == $past(a_addr, 2)
       && (!DUAL || !($past(b_we) && $past(b_addr) == $past(a_addr))))
      |-> a_dout[k*LW +: LW] == $past(a_din[k*LW +: LW], 2)); // R3

    if (DUAL) begin : g_b
      AST_ECHO_B: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd1 && $past(b_we) && $past(byteena[2+k]))
        |-> b_dout[k*LW +: LW] == $past(b_din[k*LW +: LW])); // R9
    end
  end

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd2 && !$past(a_we) && !$past(a_we, 2)
     && $past(a_addr) == $past(a_addr, 2)
     && (!DUAL || !($past(b_we, 2) && $past(b_addr, 2) == $past(a_addr, 2))))
    |-> $stable(a_dout)); // R6

endmodule

bind bytemask_ram bmr_checker #(
  .DATA_W(DATA_W),
  .ADDR_W(ADDR_W),
  .MODE  (MODE)
) u_chk (.*);

// File: tb/bytemask_ram_test.sv
module bytemask_ram_test;
  import bmr_pkg::*;

  typedef struct packed {
    logic [2:0]  port;
    logic [35:0] e;
    logic [35:0] m;
  } item_t;

  logic clk;
  logic rst_n;
  int   n_run;
  int   n_fail;

  logic        a_we, b_we, s_we;
  logic [7:0]  a_addr, b_addr, s_addr;
  logic [17:0] a_din, b_din;
  logic [35:0] s_din;
  logic [3:0]  be;

  logic [17:0] d_a_dout, d_b_dout;
  logic [35:0] s_a_dout, s_b_dout;
  logic [7:0]  n_a_dout, n_b_dout;

  logic [17:0] ref_d [256];
  logic [35:0] ref_s [256];
  logic [7:0]  ref_n [256];

  item_t q_item [$];
  string q_req  [$];

  initial clk = 1'b0;
  always #5 clk = ~clk;

  bytemask_ram #(.DATA_W(18), .ADDR_W(8), .MODE(BMR_DUAL)) uut (
    .clk(clk), .rst_n(rst_n),
    .a_we(a_we), .a_addr(a_addr), .a_din(a_din), .a_dout(d_a_dout),
    .b_we(b_we), .b_addr(b_addr), .b_din(b_din), .b_dout(d_b_dout),
    .byteena(be));

  bytemask_ram #(.DATA_W(36), .ADDR_W(8), .MODE(BMR_SINGLE)) uut_s (
    .clk(clk), .rst_n(rst_n),
    .a_we(s_we), .a_addr(s_addr), .a_din(s_din), .a_dout(s_a_dout),
    .b_we(1'b0), .b_addr(8'd0), .b_din(36'd0), .b_dout(s_b_dout),
    .byteena(be));

  bytemask_ram #(.DATA_W(8), .ADDR_W(8), .MODE(BMR_SINGLE)) uut_n (
    .clk(clk), .rst_n(rst_n),
    .a_we(s_we), .a_addr(s_addr), .a_din(s_din[7:0]), .a_dout(n_a_dout),
    .b_we(1'b0), .b_addr(8'd0), .b_din(8'd0), .b_dout(n_b_dout),
    .byteena(be));

  function automatic logic [35:0] mask9(input logic [3:0] en, input int nl);
    logic [35:0] m = '0;
    for (int k = 0; k < nl; k++) if (en[k]) m[9*k +: 9] = 9'h1FF;
    return m;
  endfunction

  task automatic push(input logic [2:0] port, input logic [35:0] e,
                      input logic [35:0] m, input string req);
    item_t it;
    it.port = port; it.e = e; it.m = m;
    q_item.push_back(it);
    q_req.push_back(req);
  endtask

  // Driver: one clock cycle of stimulus on all three instances.
  task automatic cyc(input logic awe, input logic [7:0] aad, input logic [17:0] adi,
                     input logic bwe, input logic [7:0] bad, input logic [17:0] bdi,
                     input logic swe, input logic [7:0] sad, input logic [35:0] sdi,
                     input logic [3:0] en, input string req);
    logic [17:0] ma, mb;
    logic [35:0] ms;
    @(negedge clk);
    a_we = awe; a_addr = aad; a_din = adi;
    b_we = bwe; b_addr = bad; b_din = bdi;
    s_we = swe; s_addr = sad; s_din = sdi; be = en;
    ma = mask9({2'b00, en[1:0]}, 2);
    mb = mask9({2'b00, en[3:2]}, 2);
    ms = mask9(en, 4);
    push(3'd0, awe ? {18'd0, adi} : {18'd0, ref_d[aad]}, awe ? {18'd0, ma} : {18'd0, 18'h3FFFF}, req);
    push(3'd1, bwe ? {18'd0, bdi} : {18'd0, ref_d[bad]}, bwe ? {18'd0, mb} : {18'd0, 18'h3FFFF}, req);
    push(3'd2, swe ? sdi : ref_s[sad], swe ? ms : {36{1'b1}}, req);
    push(3'd3, 36'd0, {36{1'b1}}, "R8");
    push(3'd4, swe ? {28'd0, sdi[7:0]} : {28'd0, ref_n[sad]},
         (swe && !en[0]) ? 36'd0 : 36'hFF, req);
    // reference update: port B first, port A last (R11)
    if (bwe) ref_d[bad] = (ref_d[bad] & ~mb) | (bdi & mb);
    if (awe) ref_d[aad] = (ref_d[aad] & ~ma) | (adi & ma);
    if (swe) ref_s[sad] = (ref_s[sad] & ~ms) | (sdi & ms);
    if (swe && en[0]) ref_n[sad] = sdi[7:0];
  endtask

  task automatic rd(input logic [7:0] aad, input logic [7:0] bad, input logic [7:0] sad,
                    input string req);
    cyc(1'b0, aad, 18'h155AA, 1'b0, bad, 18'h2A955, 1'b0, sad, 36'hF0F0F0F0F, 4'hF, req);
  endtask

  // Monitor: compare design outputs right after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      while (q_item.size() > 0) begin
        item_t it;
        string rq;
        logic [35:0] act;
        it = q_item.pop_front();
        rq = q_req.pop_front();
        case (it.port)
          3'd0:    act = {18'd0, d_a_dout};
          3'd1:    act = {18'd0, d_b_dout};
          3'd2:    act = s_a_dout;
          3'd3:    act = s_b_dout;
          default: act = {28'd0, n_a_dout};
        endcase
        n_run++;
        if ((act & it.m) !== (it.e & it.m)) begin
          n_fail++;
          $display("FAIL %s port%0d actual=%h expected=%h mask=%h", rq, it.port,
                   act & it.m, it.e & it.m, it.m);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    n_run = 0; n_fail = 0;
    rst_n = 1'b1;
    a_we = 0; b_we = 0; s_we = 0; a_addr = 0; b_addr = 0; s_addr = 0;
    a_din = 0; b_din = 0; s_din = 0; be = 4'hF;
    for (int i = 0; i < 256; i++) begin ref_d[i] = 'x; ref_s[i] = 'x; ref_n[i] = 'x; end
    #1 rst_n = 1'b0;
    #20;
    n_run++;  // R12: outputs zero in reset
    if ({d_a_dout, d_b_dout, s_a_dout, n_a_dout} !== '0) begin
      n_fail++;
      $display("FAIL R12 actual=%h expected=0", {d_a_dout, d_b_dout, s_a_dout, n_a_dout});
    end
    @(negedge clk) rst_n = 1'b1;

    // R3 fill: full-lane writes on every instance
    for (int i = 0; i < 8; i++)
      cyc(1'b1, 8'(i), 18'h10000 + 18'(i * 4099), 1'b1, 8'(i + 16), 18'h20000 + 18'(i * 777),
          1'b1, 8'(i), 36'h123456789 + 36'(i * 36'h111111111), 4'hF, "R3");
    // R2 readback, one new address per cycle
    for (int i = 0; i < 8; i++) rd(8'(i), 8'(i + 16), 8'(i), "R2");

    // R9 lane split: A lane0 only, B lane1 only
    cyc(1'b1, 8'd0, 18'h3FFFF, 1'b1, 8'd16, 18'h3FFFF, 1'b0, 8'd0, 36'd0, 4'b1001, "R9");
    rd(8'd0, 8'd16, 8'd0, "R9");
    cyc(1'b1, 8'd1, 18'h00000, 1'b1, 8'd17, 18'h00000, 1'b0, 8'd0, 36'd0, 4'b0110, "R9");
    rd(8'd1, 8'd17, 8'd1, "R9");

    // R1 / R8 lane positions on the 36-bit single port, one lane at a time
    for (int k = 0; k < 4; k++) begin
      cyc(1'b0, 8'd0, 18'd0, 1'b0, 8'd0, 18'd0, 1'b1, 8'(2 + k), 36'hABCDEF012, 4'(1 << k), "R1");
      rd(8'd0, 8'd16, 8'(2 + k), "R1");
    end
    cyc(1'b0, 8'd0, 18'd0, 1'b0, 8'd0, 18'd0, 1'b1, 8'd6, 36'h000000000, 4'b0101, "R8");
    rd(8'd0, 8'd16, 8'd6, "R8");

    // R4 enable with no lanes
    cyc(1'b1, 8'd2, 18'h2AAAA, 1'b1, 8'd18, 18'h15555, 1'b1, 8'd7, 36'hFFFFFFFFF, 4'b0000, "R4");
    rd(8'd2, 8'd18, 8'd7, "R4");

    // R6 write enable low, enables and data active
    cyc(1'b0, 8'd3, 18'h3C3C3, 1'b0, 8'd19, 18'h0F0F0, 1'b0, 8'd3, 36'hDEADBEEF5, 4'hF, "R6");
    rd(8'd3, 8'd19, 8'd3, "R6");

    // R5 narrow word: lane-0 enable gates the write
    cyc(1'b0, 8'd0, 18'd0, 1'b0, 8'd0, 18'd0, 1'b1, 8'd4, 36'h0000000C3, 4'b1110, "R5");
    rd(8'd0, 8'd16, 8'd4, "R5");
    cyc(1'b0, 8'd0, 18'd0, 1'b0, 8'd0, 18'd0, 1'b1, 8'd4, 36'h0000000C3, 4'b0001, "R5");
    rd(8'd0, 8'd16, 8'd4, "R5");

    // R7 write-cycle echo, mixed lanes on all ports
    cyc(1'b1, 8'd8, 18'h1E1E1, 1'b1, 8'd24, 18'h2D2D2, 1'b1, 8'd8, 36'h5A5A5A5A5, 4'b1011, "R7");
    rd(8'd8, 8'd24, 8'd8, "R7");

    // R10 A writes address 5 while B reads it: B sees old word, then new
    cyc(1'b1, 8'd5, 18'h0BEEF, 1'b0, 8'd5, 18'd0, 1'b0, 8'd0, 36'd0, 4'b0011, "R10");
    rd(8'd0, 8'd5, 8'd0, "R10");
    // and the reverse direction
    cyc(1'b0, 8'd21, 18'd0, 1'b1, 8'd21, 18'h1CAFE, 1'b0, 8'd0, 36'd0, 4'b1100, "R10");
    rd(8'd21, 8'd0, 8'd0, "R10");

    // R11 same-address write collision: lane0 both, lane1 only B
    cyc(1'b1, 8'd6, 18'h11111, 1'b1, 8'd6, 18'h32222, 1'b0, 8'd0, 36'd0, 4'b1101, "R11");
    rd(8'd6, 8'd6, 8'd0, "R11");

    @(negedge clk);
    a_we = 0; b_we = 0; s_we = 0;
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule